// File: doc/BRIEF.md
# Key-Protected Software Reset Bank

This block holds a bank of active-high reset lines for peripherals and lets software drive each line from a 32-bit register bus. A single reset register holds one bit per line. Setting a bit asserts that line and clearing it releases the line. A write to this register takes effect only if its most significant byte carries a fixed unlock key. A stray or corrupted store therefore cannot reset a peripheral.

An optional enable register can be built in. It holds one bit per line and decides which lines the reset register may drive at all. When it is present, the intended software sequence is as follows. Set a line's enable bit, then assert the line. Later, release the line, then clear its enable bit. The enable register needs no key.

Software changes one line by reading the reset register, editing one bit and writing the word back with the key. The block returns the current bits on a read and masks the key byte to zero. Each output is registered, so it follows the register state one clock after the write.

Top module: `swrst_bank`

## Requirements
- R1: After the synchronous reset, every reset bit, every enable bit and every output line is 0. A read of either register returns 0.
- R2: A write to offset 0x18 whose bits 31:24 equal 0x88 loads bits NUM_LINES-1:0 into the reset bits. A following read of 0x18 returns them.
- R3: A write to offset 0x18 whose bits 31:24 hold any value other than 0x88 changes neither the reset bits nor the outputs.
- R4: Write data above bit NUM_LINES-1 stores nothing. Reads return 0 in bits 31:NUM_LINES, which includes the key byte 31:24.
- R5: When the enable register is built (HAS_ENABLE=1), a write to offset 0xFC loads bits NUM_LINES-1:0 into the enable mask with no key. A read of 0xFC returns that mask.
- R6: With the enable register built, line i is 1 exactly when reset bit i and enable bit i are both 1. The output changes on the clock edge after the edge that writes the register.
- R7: A read strobe at offset 0x18 or 0xFC puts the register contents on bus_rdata at the clock edge of the strobe. That value holds until the next read strobe.
- R8: A write to any other offset changes no register and no output. A read of any other offset returns 0.
- R9: With HAS_ENABLE=0, each output follows its reset bit directly, one edge after the write. Offset 0xFC then behaves as an unmapped offset.
- R10: Clearing an enable bit while the reset bit is still 1 releases that line. The reset bit keeps its value in the 0x18 read-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| rst_lines | output | NUM_LINES | Active-high reset outputs, one per line |

## Verification
Several internal faults show up at the ports within two cycles of the write that exposes them. A wrong key compare shows as a reset bit or line that changes after a write with a bad key. A wrong gating term shows as a line that is high while its enable bit reads 0, or a line that stays low with both bits set. A fault in the read path shows as stray ones in the key byte, or as data that differs from the written pattern, on the read right after the write. The sweeps cover every reset pattern of a small bank against several masks, and every key value. This leaves no single bit or key value untested.

// File: rtl/swrst_pkg.sv
package swrst_pkg;

  localparam logic [7:0] OFS_RESET  = 8'h18;
  localparam logic [7:0] OFS_ENABLE = 8'hFC;
  localparam logic [7:0] UNLOCK_KEY = 8'h88;

  typedef enum logic [1:0] {
    TGT_NONE   = 2'd0,
    TGT_RESET  = 2'd1,
    TGT_ENABLE = 2'd2
  } tgt_e;

endpackage

// File: rtl/swrst_decode.sv
module swrst_decode
  import swrst_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter bit HAS_ENABLE = 1'b1
) (
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        key_byte,
  output logic              reset_we,
  output logic              enable_we,
  output logic              rd_en,
  output tgt_e              rd_tgt
);

  localparam logic [ADDR_W-1:0] A_RESET  = ADDR_W'(OFS_RESET);
  localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(OFS_ENABLE);

  tgt_e tgt;

  always_comb begin
    tgt = TGT_NONE;
    if (bus_addr == A_RESET) begin
      tgt = TGT_RESET;
    end else if (HAS_ENABLE && (bus_addr == A_ENABLE)) begin
      tgt = TGT_ENABLE;
    end
  end

  assign reset_we  = bus_wr && (tgt == TGT_RESET) && (key_byte == UNLOCK_KEY);
  assign enable_we = bus_wr && (tgt == TGT_ENABLE);
  assign rd_en     = bus_rd;
  assign rd_tgt    = tgt;

endmodule

// File: rtl/swrst_reg.sv
module swrst_reg #(
  parameter int WIDTH = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (we) begin
      q <= d;
    end
  end

  // R1
  reg_clear_chk: assert property (@(posedge clk) rst |=> (q == '0));

endmodule

// File: rtl/swrst_gate.sv
module swrst_gate #(
  parameter int NUM_LINES  = 24,
  parameter bit HAS_ENABLE = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] reset_bits,
  input  logic [NUM_LINES-1:0] enable_bits,
  output logic [NUM_LINES-1:0] lines
);

  logic [NUM_LINES-1:0] drive;

  generate
    if (HAS_ENABLE) begin : g_gated
      for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        assign drive[i] = reset_bits[i] & enable_bits[i];
      end

      // R6 R10
      gated_off_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((lines & ~$past(enable_bits)) == '0));
    end else begin : g_direct
      assign drive = reset_bits;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      lines <= '0;
    end else begin
      lines <= drive;
    end
  end

  // R1
  lines_clear_chk: assert property (@(posedge clk) rst |=> (lines == '0));

endmodule

// File: rtl/swrst_bank.sv
module swrst_bank
  import swrst_pkg::*;
#(
  parameter int NUM_LINES  = 24,
  parameter bit HAS_ENABLE = 1'b1,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic [NUM_LINES-1:0] rst_lines
);

  localparam int KEY_LSB = DATA_W - 8;
  localparam int PAD_W   = DATA_W - NUM_LINES;

  logic                 reset_we;
  logic                 enable_we;
  logic                 rd_en;
  tgt_e                 rd_tgt;
  logic [NUM_LINES-1:0] reset_q;
  logic [NUM_LINES-1:0] enable_q;

  swrst_decode #(
    .ADDR_W     (ADDR_W),
    .HAS_ENABLE (HAS_ENABLE)
  ) u_decode (
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .key_byte  (bus_wdata[DATA_W-1:KEY_LSB]),
    .reset_we  (reset_we),
    .enable_we (enable_we),
    .rd_en     (rd_en),
    .rd_tgt    (rd_tgt)
  );

  swrst_reg #(.WIDTH(NUM_LINES)) u_reset_reg (
    .clk (clk),
    .rst (rst),
    .we  (reset_we),
    .d   (bus_wdata[NUM_LINES-1:0]),
    .q   (reset_q)
  );

  generate
    if (HAS_ENABLE) begin : g_enable
      swrst_reg #(.WIDTH(NUM_LINES)) u_enable_reg (
        .clk (clk),
        .rst (rst),
        .we  (enable_we),
        .d   (bus_wdata[NUM_LINES-1:0]),
        .q   (enable_q)
      );
    end else begin : g_no_enable
      assign enable_q = '0;
    end
  endgenerate

  swrst_gate #(
    .NUM_LINES  (NUM_LINES),
    .HAS_ENABLE (HAS_ENABLE)
  ) u_gate (
    .clk         (clk),
    .rst         (rst),
    .reset_bits  (reset_q),
    .enable_bits (enable_q),
    .lines       (rst_lines)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd_en) begin
      case (rd_tgt)
        TGT_RESET:  bus_rdata <= {{PAD_W{1'b0}}, reset_q};
        TGT_ENABLE: bus_rdata <= {{PAD_W{1'b0}}, enable_q};
        default:    bus_rdata <= '0;
      endcase
    end
  end

  // R2
  key_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(OFS_RESET) && bus_wdata[DATA_W-1:KEY_LSB] == UNLOCK_KEY)
    |=> (reset_q == $past(bus_wdata[NUM_LINES-1:0])));

  // R3
  key_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(OFS_RESET) && bus_wdata[DATA_W-1:KEY_LSB] != UNLOCK_KEY)
    |=> $stable(reset_q));

  // R4
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> (bus_rdata[DATA_W-1:NUM_LINES] == '0));

  // R7
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

  // R8
  unmapped_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr != ADDR_W'(OFS_RESET) && bus_addr != ADDR_W'(OFS_ENABLE))
    |=> $stable(reset_q));

endmodule

// File: tb/tb_swrst_bank.sv
module tb_swrst_bank;

  localparam int CLK_PERIOD = 10;
  localparam int N          = 8;
  localparam int DW         = 32;
  localparam int WATCHDOG   = 150000;

  logic          clk = 1'b0;
  logic          rst;
  logic          bus_wr, bus_rd;
  logic [7:0]    bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] rdata_a, rdata_b;
  logic [N-1:0]  lines_a, lines_b;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swrst_bank #(.NUM_LINES(N), .HAS_ENABLE(1'b1)) dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_a), .rst_lines(lines_a));

  swrst_bank #(.NUM_LINES(N), .HAS_ENABLE(1'b0)) dut_noen (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_b), .rst_lines(lines_b));

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  function automatic logic [DW-1:0] key_word(input logic [7:0] k, input logic [N-1:0] v);
    return {k, 16'h0000, v};
  endfunction

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] masks [4] = '{8'h00, 8'hFF, 8'hA5, 8'h3C};
    logic [N-1:0] cur;
    rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 lines", 32'(lines_a), 0);
    check("R1 lines noen", 32'(lines_b), 0);
    rd(8'h18); check("R1 rd reset", rdata_a, 0);
    rd(8'hFC); check("R1 rd enable", rdata_a, 0);

    // R5 R2 R6 R9 sweep all patterns against several masks
    for (int m = 0; m < 4; m++) begin
      wr(8'hFC, 32'(masks[m]));
      rd(8'hFC);
      check("R5 enable readback", rdata_a, 32'(masks[m]));
      check("R9 enable unmapped", rdata_b, 0);
      for (int p = 0; p < 256; p++) begin
        wr(8'h18, key_word(8'h88, N'(p)));
        rd(8'h18);
        check("R2 readback", rdata_a, 32'(p));
        check("R6 gated line", 32'(lines_a), 32'(N'(p) & masks[m]));
        check("R9 direct line", 32'(lines_b), 32'(p));
      end
    end

    // R3 every wrong key leaves state alone
    wr(8'hFC, 32'hFF);
    wr(8'h18, key_word(8'h88, 8'h5A));
    cur = 8'h5A;
    for (int k = 0; k < 256; k++) begin
      if (k != 8'h88) begin
        wr(8'h18, key_word(8'(k), ~cur));
        rd(8'h18);
        check("R3 key reject readback", rdata_a, 32'(cur));
        check("R3 key reject line", 32'(lines_a), 32'(cur));
      end
    end

    // R4 high data bits store nothing
    wr(8'h18, 32'h88FFFF00 | 32'h000000C3);
    rd(8'h18);
    check("R4 upper bits", rdata_a, 32'h000000C3);
    wr(8'hFC, 32'hFFFFFF0F);
    rd(8'hFC);
    check("R4 enable upper bits", rdata_a, 32'h0000000F);

    // R7 read data holds across idle cycles and writes
    repeat (4) @(negedge clk);
    wr(8'h18, key_word(8'h88, 8'h11));
    check("R7 rdata hold", rdata_a, 32'h0000000F);

    // R8 unmapped offsets
    wr(8'h1C, key_word(8'h88, 8'hEE));
    wr(8'h00, 32'hFF);
    rd(8'h18);
    check("R8 unmapped write", rdata_a, 32'h11);
    rd(8'h1C);
    check("R8 unmapped read", rdata_a, 0);
    wr(8'hFC, 32'hAA);
    rd(8'hFC);
    check("R9 noen 0xFC write ignored", rdata_b, 0);

    // R10 sequence: enable, assert, drop enable, release
    wr(8'hFC, 32'h04);
    wr(8'h18, key_word(8'h88, 8'h04));
    rd(8'h18);
    check("R10 asserted", 32'(lines_a), 32'h04);
    wr(8'hFC, 32'h00);
    rd(8'h18);
    check("R10 released by enable", 32'(lines_a), 0);
    check("R10 bit retained", rdata_a, 32'h04);
    wr(8'h18, key_word(8'h88, 8'h00));
    rd(8'h18);
    check("R10 cleared", rdata_a, 0);

    // R1 reset mid-run clears everything
    wr(8'hFC, 32'hFF);
    wr(8'h18, key_word(8'h88, 8'hFF));
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 lines after reset", 32'(lines_a), 0);
    rd(8'hFC);
    check("R1 enable after reset", rdata_a, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule